// File: doc/BRIEF.md
# Table Pointer Access Sequencer

This block carries out the table transfer instructions of a small processor core. Each one moves a single byte between program memory and an 8-bit holding latch. The block holds a 21-bit table pointer and the byte latch. It decodes each incoming instruction word to find the direction (read or write) and how the pointer moves. It then drives a plain synchronous memory port with an address, a read strobe, a write strobe and data in each direction. Every table instruction takes exactly two cycles. The pointer is stepped either before the access (pre-increment) or after it (post-increment and post-decrement), or it is left alone. No status flags exist or change.

Instruction words arrive on a valid/ready stream. The producer raises `insn_valid` with a word and holds both until a cycle in which `insn_ready` is also high; the word is taken on that clock edge. `insn_ready` never depends on `insn_valid`. It is low during the first cycle of an instruction and low for as long as a programming cycle is busy, and that is how back-pressure reaches the producer. The pointer and latch can be preset from plain load pins; a load takes effect only while no instruction is in flight. A table write can start a long internal programming cycle. When `wr_start` is high during the first cycle of a write, `busy` rises and new instructions stall until a `wr_term` pulse arrives.

Top module: `tbl_access_seq`

## Requirements
- R1: After reset, `ptr_o` and `latch_o` are 0, `busy` is 0, `insn_ready` is 1 and neither memory strobe is high.
- R2: A word is a table instruction when bits 15:4 are all zero and bit 3 is one. Bit 2 selects read (0) or write (1). Any other accepted word is consumed with no memory access and no change to pointer or latch.
- R3: Bits 1:0 select the pointer action. 00 leaves the pointer unchanged, 01 adds one after the access, 10 subtracts one after the access, and 11 adds one before the access. In modes 00, 01 and 10 the access address is the old pointer.
- R4: In mode 11 the access address is the incremented pointer, and the pointer keeps that value.
- R5: The pointer wraps modulo 2^21: one past 0x1FFFFF is 0, and one below 0 is 0x1FFFFF.
- R6: The cycle after a table word is accepted, exactly one strobe (`mem_rd` or `mem_wr`) is high. `insn_ready` is low in that cycle and, unless busy, high again in the second cycle, so an instruction occupies two cycles.
- R7: On a read, `mem_rdata` presented one cycle after `mem_rd` is captured into the latch at the end of the second cycle.
- R8: On a write, `mem_wdata` carries the latch value while `mem_wr` is high, and the latch is not changed.
- R9: If `wr_start` is high in the strobe cycle of a write, `busy` is set on the following edge and stays high until a cycle with `wr_term` high. While `busy` is high, `insn_ready` is low and no strobe is issued.
- R10: `wr_start` has no effect during a read.
- R11: A pulse on `ptr_ld_en` or `lat_ld_en` while the sequencer is idle replaces the pointer or latch with the supplied value at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction word is offered |
| insn_ready | output | 1 | Sequencer can take a word this cycle |
| insn_word | input | 16 | Instruction word |
| ptr_ld_en | input | 1 | Preset the pointer (idle only) |
| ptr_ld_data | input | 21 | Pointer preset value |
| lat_ld_en | input | 1 | Preset the latch (idle only) |
| lat_ld_data | input | 8 | Latch preset value |
| ptr_o | output | 21 | Current table pointer |
| latch_o | output | 8 | Current table latch |
| mem_addr | output | 21 | Memory address, valid while a strobe is high |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, one cycle after the read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data (the latch) |
| wr_start | input | 1 | Write starts an internal programming cycle |
| wr_term | input | 1 | Ends the programming cycle |
| busy | output | 1 | Programming cycle in progress |

## Verification
The hardest state to reach from the ports is an instruction waiting behind a busy programming cycle. The producer must have a word already offered while `busy` holds `insn_ready` low, and the word must go out only after `wr_term`. The bench starts a write with `wr_start` high and forks a second instruction that waits on `insn_ready`. It checks for several cycles that no strobe appears. It then pulses `wr_term` and has the scoreboard match the delayed access. The pointer wrap points are reached by presetting the pointer to each end of the 21-bit range before a post-increment and a post-decrement.

// File: rtl/tbl_access_pkg.sv
package tbl_access_pkg;
  localparam int INSN_W = 16;

  typedef enum logic [1:0] {
    MODE_HOLD     = 2'b00,
    MODE_POST_INC = 2'b01,
    MODE_POST_DEC = 2'b10,
    MODE_PRE_INC  = 2'b11
  } ptr_mode_e;

  typedef struct packed {
    logic      wr;
    ptr_mode_e mode;
  } tbl_op_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_C1   = 2'b01,
    ST_C2   = 2'b10
  } seq_state_e;
endpackage

// File: rtl/tbl_decode.sv
module tbl_decode
  import tbl_access_pkg::*;
(
  input  logic [INSN_W-1:0] word_i,
  output logic              is_table_o,
  output tbl_op_t           op_o
);
  localparam int TOP_W = INSN_W - 4;

  always_comb begin
    is_table_o = (word_i[INSN_W-1:4] == TOP_W'(0)) && word_i[3];
    op_o.wr    = word_i[2];
    op_o.mode  = ptr_mode_e'(word_i[1:0]);
  end
endmodule

// File: rtl/tbl_ptr_unit.sv
module tbl_ptr_unit
  import tbl_access_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  ptr_mode_e         mode_i,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_data_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] ptr_q, ptr_inc, ptr_dec, ptr_nxt;

  assign ptr_inc = ptr_q + ADDR_W'(1);
  assign ptr_dec = ptr_q - ADDR_W'(1);

  always_comb begin
    unique case (mode_i)
      MODE_POST_INC, MODE_PRE_INC: ptr_nxt = ptr_inc;
      MODE_POST_DEC:               ptr_nxt = ptr_dec;
      default:                     ptr_nxt = ptr_q;
    endcase
  end

  assign addr_o = (mode_i == MODE_PRE_INC) ? ptr_inc : ptr_q;
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (step_i) ptr_q <= ptr_nxt;
    else if (ld_i)   ptr_q <= ld_data_i;
  end

  AST_PRE_ADDR_IS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && mode_i == MODE_PRE_INC) |=> (ptr_q == $past(addr_o))); // R4
endmodule

// File: rtl/tbl_seq_ctrl.sv
module tbl_seq_ctrl
  import tbl_access_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    insn_valid_i,
  input  logic    is_table_i,
  input  tbl_op_t op_i,
  input  logic    wr_start_i,
  input  logic    wr_term_i,
  output logic    insn_ready_o,
  output logic    busy_o,
  output logic    in_c1_o,
  output logic    in_c2_o,
  output logic    idle_o,
  output tbl_op_t op_o
);
  seq_state_e state_q, state_nxt;
  tbl_op_t    op_q;
  logic       busy_q, take;

  assign insn_ready_o = !busy_q && (state_q != ST_C1);
  assign take         = insn_valid_i && insn_ready_o && is_table_i;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE: if (take) state_nxt = ST_C1;
      ST_C1:   state_nxt = ST_C2;
      ST_C2:   state_nxt = take ? ST_C1 : ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      if (take) op_q <= op_i;
      if (busy_q && wr_term_i)                            busy_q <= 1'b0;
      else if (state_q == ST_C1 && op_q.wr && wr_start_i) busy_q <= 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign in_c1_o = (state_q == ST_C1);
  assign in_c2_o = (state_q == ST_C2);
  assign idle_o  = (state_q == ST_IDLE);
  assign op_o    = op_q;

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !wr_term_i) |=> busy_q); // R9
  AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !insn_ready_o); // R9
  AST_C1_THEN_C2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_C1) |=> (state_q == ST_C2)); // R6
endmodule

// File: rtl/tbl_access_seq.sv
module tbl_access_seq
  import tbl_access_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  output logic              insn_ready,
  input  logic [15:0]       insn_word,
  input  logic              ptr_ld_en,
  input  logic [ADDR_W-1:0] ptr_ld_data,
  input  logic              lat_ld_en,
  input  logic [DATA_W-1:0] lat_ld_data,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [DATA_W-1:0] latch_o,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              wr_start,
  input  logic              wr_term,
  output logic              busy
);
  logic              is_table, in_c1, in_c2, idle;
  tbl_op_t           dec_op, cur_op;
  logic [DATA_W-1:0] latch_q;

  tbl_decode u_dec (
    .word_i     (insn_word),
    .is_table_o (is_table),
    .op_o       (dec_op)
  );

  tbl_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_valid_i (insn_valid),
    .is_table_i   (is_table),
    .op_i         (dec_op),
    .wr_start_i   (wr_start),
    .wr_term_i    (wr_term),
    .insn_ready_o (insn_ready),
    .busy_o       (busy),
    .in_c1_o      (in_c1),
    .in_c2_o      (in_c2),
    .idle_o       (idle),
    .op_o         (cur_op)
  );

  tbl_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (in_c1),
    .mode_i    (cur_op.mode),
    .ld_i      (ptr_ld_en && idle),
    .ld_data_i (ptr_ld_data),
    .ptr_o     (ptr_o),
    .addr_o    (mem_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    latch_q <= '0;
    else if (in_c2 && !cur_op.wr)  latch_q <= mem_rdata;
    else if (lat_ld_en && idle)    latch_q <= lat_ld_data;
  end

  assign latch_o   = latch_q;
  assign mem_rd    = in_c1 && !cur_op.wr;
  assign mem_wr    = in_c1 &&  cur_op.wr;
  assign mem_wdata = latch_q;

  AST_STROBE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_ready && is_table) |=> (mem_rd ^ mem_wr)); // R6
  AST_HOLD_MODE_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_c1 && cur_op.mode == MODE_HOLD) |=> $stable(ptr_o)); // R3
  AST_WRITE_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> $stable(latch_o)); // R8
  AST_READ_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !busy) |=> !busy); // R10
  AST_NO_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(mem_rd || mem_wr)); // R9
endmodule

// File: tb/test_tbl_access_seq.sv
module test_tbl_access_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          insn_valid = 1'b0, insn_ready;
  logic [15:0]   insn_word = '0;
  logic          ptr_ld_en = 1'b0, lat_ld_en = 1'b0;
  logic [AW-1:0] ptr_ld_data = '0, ptr_o, mem_addr;
  logic [7:0]    lat_ld_data = '0, latch_o, mem_rdata = '0, mem_wdata;
  logic          mem_rd, mem_wr, wr_start = 1'b0, wr_term = 1'b0, busy;

  int checks = 0, failures = 0;
  logic [AW-1:0] m_ptr = '0;
  logic [7:0]    m_lat = '0;
  logic [AW+8:0] exp_q [$];   // {wr, addr, wdata}

  always #(CLK_PERIOD/2) clk = ~clk;

  tbl_access_seq i_tbl_access_seq (.*);

  function automatic logic [7:0] mem_val(input logic [AW-1:0] a);
    return a[7:0] ^ {a[20:16], 3'b101} ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_val(mem_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: compare every strobe against the scoreboard
  always @(negedge clk) begin
    if (rst_n && (mem_rd || mem_wr)) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected access", {mem_wr, mem_addr}, 0);
      else begin
        logic [AW+8:0] e;
        e = exp_q.pop_front();
        chk(!(mem_rd && mem_wr), "R6 one strobe", {mem_rd, mem_wr}, 1);
        chk(mem_wr == e[AW+8] && mem_addr == e[AW+7:8], "R3 access addr/dir",
            {mem_wr, mem_addr}, e[AW+8:8]);
        if (mem_wr) chk(mem_wdata == e[7:0], "R8 write data", mem_wdata, e[7:0]);
      end
    end
  end

  // driver: model the instruction, push expectation, hand the word over
  task automatic issue(input logic [15:0] w);
    bit tbl;
    tbl = (w[15:4] == 12'h0) && w[3];
    if (tbl) begin
      logic [AW-1:0] a;
      a = (w[1:0] == 2'b11) ? m_ptr + 1'b1 : m_ptr;
      exp_q.push_back({w[2], a, m_lat});
      case (w[1:0])
        2'b01, 2'b11: m_ptr = m_ptr + 1'b1;
        2'b10:        m_ptr = m_ptr - 1'b1;
        default: ;
      endcase
      if (!w[2]) m_lat = mem_val(a);
    end
    @(negedge clk);
    while (!insn_ready) @(negedge clk);
    insn_valid = 1'b1; insn_word = w;
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  task automatic settle_and_check(input string tag);
    repeat (3) @(negedge clk);
    chk(ptr_o == m_ptr, tag, ptr_o, m_ptr);
    chk(latch_o == m_lat, tag, latch_o, m_lat);
  endtask

  task automatic load_ptr(input logic [AW-1:0] v);
    @(negedge clk); ptr_ld_en = 1'b1; ptr_ld_data = v;
    @(negedge clk); ptr_ld_en = 1'b0; m_ptr = v;
    chk(ptr_o == v, "R11 pointer load", ptr_o, v);
  endtask

  task automatic load_lat(input logic [7:0] v);
    @(negedge clk); lat_ld_en = 1'b1; lat_ld_data = v;
    @(negedge clk); lat_ld_en = 1'b0; m_lat = v;
    chk(latch_o == v, "R11 latch load", latch_o, v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ptr_o == 0 && latch_o == 0, "R1 reset ptr/latch", {ptr_o, latch_o}, 0);
    chk(!busy && insn_ready && !mem_rd && !mem_wr, "R1 reset ctl",
        {busy, insn_ready, mem_rd, mem_wr}, 4'b0100);
    rst_n = 1'b1;

    // R6 timing: ready low in first cycle, back in second
    load_ptr(21'h00_0100);
    @(negedge clk); insn_valid = 1'b1; insn_word = 16'h0008;
    exp_q.push_back({1'b0, 21'h00_0100, 8'h00}); m_lat = mem_val(21'h00_0100);
    @(negedge clk); insn_valid = 1'b0;
    chk(!insn_ready && mem_rd, "R6 first cycle", {insn_ready, mem_rd}, 2'b01);
    @(negedge clk);
    chk(insn_ready && !mem_rd, "R6 second cycle", {insn_ready, mem_rd}, 2'b10);
    settle_and_check("R7 read hold-mode latch");

    // R3 post modes, R5 wrap
    load_ptr(21'h1F_FFFF);
    issue(16'h0009); settle_and_check("R5 post-inc wrap");
    chk(ptr_o == 0, "R5 wrap to zero", ptr_o, 0);
    issue(16'h000A); settle_and_check("R5 post-dec wrap");
    chk(ptr_o == 21'h1F_FFFF, "R5 wrap to max", ptr_o, 21'h1F_FFFF);
    // R4 pre-increment
    load_ptr(21'h0A_1234);
    issue(16'h000B); settle_and_check("R4 pre-inc");
    issue(16'h000A); settle_and_check("R3 post-dec");

    // R2 non-table words ignored
    issue(16'h0018); issue(16'h1009); issue(16'h0007);
    settle_and_check("R2 non-table ignored");

    // R8 writes, R10 wr_start ignored on reads
    load_lat(8'hA5);
    issue(16'h000D); settle_and_check("R8 write post-inc");
    wr_start = 1'b1;
    issue(16'h0009); settle_and_check("R10 read");
    chk(!busy, "R10 no busy after read", busy, 0);

    // R9 busy and stall
    load_lat(8'h5E);
    issue(16'h000F);
    repeat (2) @(negedge clk);
    wr_start = 1'b0;
    chk(busy, "R9 busy set", busy, 1);
    fork issue(16'h000B); join_none
    repeat (8) begin
      @(negedge clk);
      chk(busy && !insn_ready && !mem_rd && !mem_wr, "R9 stalled",
          {busy, insn_ready, mem_rd, mem_wr}, 4'b1000);
    end
    wr_term = 1'b1;
    @(negedge clk); wr_term = 1'b0;
    chk(!busy, "R9 busy cleared", busy, 0);
    wait fork;
    settle_and_check("R9 stalled read completes");
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule